// File: doc/BRIEF.md
# Snoop-Aware Tag Port Arbiter

This block decides, every cycle, who may use a single-ported cache tag array: a bus snoop lookup or a local load/store access. When both ask in the same cycle the snoop is served first and the local side is stalled for that cycle. The local side keeps its request up and is served on the following clock.

Some cycles are unsafe for a snoop because the tags are busy or about to change. In those cycles the snoop is refused and the block raises an address-retry request. These cycles are:

- a tag write;
- a burst transfer in progress;
- the committed span of a line fill, from its first data acknowledge to its last;
- the last-acknowledge collision cycle, whose position depends on the delayed-retry mode;
- a snoop whose address matches the line in the cast-out buffer;
- the first or last cycle of a zero-block operation or of a cast-out access;
- the cycle in which a flush or clean operation rewrites a hit tag.

The retry request is registered, so it appears one cycle after the snoop that caused it, in the snoop response window.

Top module: `tag_port_arbiter`

## Requirements
- R1: When a snoop and a local access request together and no busy condition holds, `snp_gnt` is 1, `loc_gnt` is 0 and `loc_stall` is 1 in that cycle. A lone local request gets `loc_gnt`=1 with `loc_stall`=0. The two grants are never both 1.
- R2: A snoop in a cycle with `tag_write`=1 is not granted and is retried.
- R3: A snoop while `burst_busy`=1 is not granted and is retried.
- R4: After a cycle with `fill_ack_first`=1, snoops are refused and retried in every later cycle up to and including the cycle with `fill_ack_last`=1. A snoop in the `fill_ack_first` cycle itself is granted, provided nothing else blocks it.
- R5: With `drtry_mode`=0, a snoop in a `fill_ack_last` cycle is retried. With `drtry_mode`=1, that cycle does not block the snoop on its own account, and the cycle `LAST_ACK_DELAY` clocks later is blocked instead.
- R6: A snoop with `castout_hit`=1 is not granted and is retried.
- R7: A snoop with `op_edge`=1 is not granted and is retried. `op_edge` marks the first or last cycle of a zero-block operation or of a cast-out load/store.
- R8: A snoop with `flush_upd`=1 is not granted and is retried. `flush_upd` marks a flush or clean tag update.
- R9: `snp_retry` is 1 exactly in the cycle after a refused snoop, and 0 after a granted snoop or a cycle with no snoop. A refused snoop leaves a pending local request granted.
- R10: While `rst_n` is 0 and for the first cycle after it, `snp_retry` is 0 and the committed and delayed-acknowledge state is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_req | input | 1 | Local load/store tag access request |
| snp_req | input | 1 | Qualified snoop lookup request |
| tag_write | input | 1 | Tag array is being written this cycle |
| burst_busy | input | 1 | Cache busy with a burst read or write |
| fill_ack_first | input | 1 | First data acknowledge of a line fill |
| fill_ack_last | input | 1 | Last data acknowledge of a line fill |
| castout_hit | input | 1 | Snoop address matches cast-out buffer line |
| op_edge | input | 1 | First/last cycle of zero-block or cast-out access |
| flush_upd | input | 1 | Flush/clean operation updating a hit tag |
| drtry_mode | input | 1 | Delayed-retry mode enable |
| snp_gnt | output | 1 | Tag port granted to snoop |
| loc_gnt | output | 1 | Tag port granted to local access |
| loc_stall | output | 1 | Local access held off by snoop |
| snp_retry | output | 1 | Registered address-retry request for the snoop |

## Verification
The bench builds the block with the default `LAST_ACK_DELAY` of 1. With that value the delayed-mode collision falls exactly one clock after the last acknowledge. Snoops placed on the acknowledge cycle itself, one cycle after it, and one cycle after that therefore separate the two retry modes. The same short delay lets a complete fill, running from first to last acknowledge, sit within a few directed cycles. This is how the committed-span boundaries are reached at both ends.

// File: rtl/tagarb_pkg.sv
// Package: shared constants and the busy-cause vector for the tag port arbiter.
// Assumes: every busy cause is a single-cycle qualified flag.
package tagarb_pkg;
    localparam int NUM_CAUSE = 7;

    typedef enum logic [2:0] {
        CAUSE_TAGWR  = 3'd0,
        CAUSE_BURST  = 3'd1,
        CAUSE_COMMIT = 3'd2,
        CAUSE_LAST   = 3'd3,
        CAUSE_CASTO  = 3'd4,
        CAUSE_EDGE   = 3'd5,
        CAUSE_FLUSH  = 3'd6
    } cause_e;

    typedef logic [NUM_CAUSE-1:0] cause_vec_t;
endpackage

// File: rtl/tagarb_window.sv
// Module: tagarb_window
// Tracks the tag-busy windows that force a snoop to retry:
//   - the committed span of a line fill, from its first to its last acknowledge;
//   - the last-acknowledge collision cycle, selected by the retry mode;
//   - the single-cycle busy flags passed through from the inputs.
// Assumes: fill_ack_first precedes or coincides with fill_ack_last, and
// LAST_ACK_DELAY >= 1.
module tagarb_window
    import tagarb_pkg::*;
#(
    parameter int LAST_ACK_DELAY = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tag_write,
    input  logic       burst_busy,
    input  logic       fill_ack_first,
    input  logic       fill_ack_last,
    input  logic       castout_hit,
    input  logic       op_edge,
    input  logic       flush_upd,
    input  logic       drtry_mode,
    output cause_vec_t cause,
    output logic       busy
);
    localparam int DW = LAST_ACK_DELAY;

    logic          committed;
    logic [DW-1:0] ack_dly;
    logic          last_hit;

    // Committed span: set after the first acknowledge, cleared after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) committed <= 1'b0;
        else        committed <= (committed | fill_ack_first) & ~fill_ack_last;
    end

    // Delay line that carries the last acknowledge for delayed-retry mode.
    generate
        if (DW == 1) begin : g_dly1
            always_ff @(posedge clk) begin
                if (!rst_n) ack_dly <= '0;
                else        ack_dly <= fill_ack_last;
            end
        end else begin : g_dlyn
            always_ff @(posedge clk) begin
                if (!rst_n) ack_dly <= '0;
                else        ack_dly <= {ack_dly[DW-2:0], fill_ack_last};
            end
        end
    endgenerate

    // Pick the collision cycle according to the retry mode.
    always_comb last_hit = drtry_mode ? ack_dly[DW-1] : fill_ack_last;

    // Collect every busy cause into one vector.
    always_comb begin
        cause               = '0;
        cause[CAUSE_TAGWR]  = tag_write;
        cause[CAUSE_BURST]  = burst_busy;
        cause[CAUSE_COMMIT] = committed;
        cause[CAUSE_LAST]   = last_hit;
        cause[CAUSE_CASTO]  = castout_hit;
        cause[CAUSE_EDGE]   = op_edge;
        cause[CAUSE_FLUSH]  = flush_upd;
    end

    // Any cause makes the tags unavailable to a snoop.
    always_comb busy = |cause;
endmodule

// File: rtl/tagarb_pick.sv
// Module: tagarb_pick
// Combinational grant logic. An unblocked snoop wins the tag port over a
// local access. A blocked snoop yields the port and is flagged for retry.
// Assumes: busy already folds in every tag-busy condition.
module tagarb_pick (
    input  logic loc_req,
    input  logic snp_req,
    input  logic busy,
    output logic snp_gnt,
    output logic loc_gnt,
    output logic loc_stall,
    output logic snp_refuse
);
    // Snoop first; the local access takes the port whenever the snoop does not.
    always_comb begin
        snp_gnt    = snp_req & ~busy;
        snp_refuse = snp_req & busy;
        loc_gnt    = loc_req & ~snp_gnt;
        loc_stall  = loc_req & snp_gnt;
    end
endmodule

// File: rtl/tag_port_arbiter.sv
// Module: tag_port_arbiter (top)
// Arbitrates a single-ported tag array between snoop lookups and local
// load/store accesses. Grants are combinational. The retry request is
// registered so that it lines up with the snoop response window one cycle
// after the snoop.
// Assumes: the local requester holds loc_req while loc_stall is high.
module tag_port_arbiter
    import tagarb_pkg::*;
#(
    parameter int LAST_ACK_DELAY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loc_req,
    input  logic snp_req,
    input  logic tag_write,
    input  logic burst_busy,
    input  logic fill_ack_first,
    input  logic fill_ack_last,
    input  logic castout_hit,
    input  logic op_edge,
    input  logic flush_upd,
    input  logic drtry_mode,
    output logic snp_gnt,
    output logic loc_gnt,
    output logic loc_stall,
    output logic snp_retry
);
    cause_vec_t cause;
    logic       busy;
    logic       snp_refuse;

    tagarb_window #(.LAST_ACK_DELAY(LAST_ACK_DELAY)) u_win (
        .clk(clk), .rst_n(rst_n),
        .tag_write(tag_write), .burst_busy(burst_busy),
        .fill_ack_first(fill_ack_first), .fill_ack_last(fill_ack_last),
        .castout_hit(castout_hit), .op_edge(op_edge), .flush_upd(flush_upd),
        .drtry_mode(drtry_mode), .cause(cause), .busy(busy)
    );

    tagarb_pick u_pick (
        .loc_req(loc_req), .snp_req(snp_req), .busy(busy),
        .snp_gnt(snp_gnt), .loc_gnt(loc_gnt), .loc_stall(loc_stall),
        .snp_refuse(snp_refuse)
    );

    // Register the refusal into the response-window retry request.
    always_ff @(posedge clk) begin
        if (!rst_n) snp_retry <= 1'b0;
        else        snp_retry <= snp_refuse;
    end
endmodule

// File: rtl/tagarb_chk.sv
// Module: tagarb_chk
// Port-level checker for tag_port_arbiter, attached by bind.
module tagarb_chk (
    input logic clk,
    input logic rst_n,
    input logic loc_req,
    input logic snp_req,
    input logic tag_write,
    input logic burst_busy,
    input logic fill_ack_last,
    input logic castout_hit,
    input logic op_edge,
    input logic flush_upd,
    input logic drtry_mode,
    input logic snp_gnt,
    input logic loc_gnt,
    input logic snp_retry
);
    assert_one_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({snp_gnt, loc_gnt}));
    assert_local_served_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_req && !snp_gnt) |-> loc_gnt);
    assert_tagwr_retry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_req && tag_write) |=> snp_retry);
    assert_burst_retry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_req && burst_busy) |=> snp_retry);
    assert_last_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_req && fill_ack_last && !drtry_mode) |=> snp_retry);
    assert_castout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_req && castout_hit) |-> !snp_gnt);
    assert_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_req && op_edge) |=> snp_retry);
    assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_req && flush_upd) |-> !snp_gnt);
    assert_grant_no_retry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_gnt |=> !snp_retry);
    assert_idle_no_retry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_req |=> !snp_retry);
endmodule

bind tag_port_arbiter tagarb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .loc_req(loc_req), .snp_req(snp_req),
    .tag_write(tag_write), .burst_busy(burst_busy),
    .fill_ack_last(fill_ack_last), .castout_hit(castout_hit),
    .op_edge(op_edge), .flush_upd(flush_upd), .drtry_mode(drtry_mode),
    .snp_gnt(snp_gnt), .loc_gnt(loc_gnt), .snp_retry(snp_retry)
);

// File: tb/sim_tag_port_arbiter.sv
// Directed bench for tag_port_arbiter. Inputs change on the falling edge.
// Grants are checked 1 ns later; the retry is checked 1 ns after the next
// rising edge.
module sim_tag_port_arbiter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loc_req = 0, snp_req = 0, tag_write = 0, burst_busy = 0;
    logic fill_ack_first = 0, fill_ack_last = 0, castout_hit = 0;
    logic op_edge = 0, flush_upd = 0, drtry_mode = 0;
    logic snp_gnt, loc_gnt, loc_stall, snp_retry;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 0;

    // Input vector bit positions.
    localparam int B_LOC = 8, B_SNP = 7, B_TW = 6, B_BB = 5, B_LA = 4;
    localparam int B_FA = 3, B_CO = 2, B_OE = 1, B_FU = 0;

    always #4 clk = ~clk;

    tag_port_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .loc_req(loc_req), .snp_req(snp_req),
        .tag_write(tag_write), .burst_busy(burst_busy),
        .fill_ack_first(fill_ack_first), .fill_ack_last(fill_ack_last),
        .castout_hit(castout_hit), .op_edge(op_edge), .flush_upd(flush_upd),
        .drtry_mode(drtry_mode), .snp_gnt(snp_gnt), .loc_gnt(loc_gnt),
        .loc_stall(loc_stall), .snp_retry(snp_retry)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One cycle: drive v, check {snp_gnt, loc_gnt, loc_stall}, then snp_retry.
    task automatic cyc(input logic [8:0] v, input logic [2:0] eg, input logic er,
                       input string req);
        @(negedge clk);
        {loc_req, snp_req, tag_write, burst_busy, fill_ack_last,
         fill_ack_first, castout_hit, op_edge, flush_upd} = v;
        #1;
        check(req, {1'b0, snp_gnt, loc_gnt, loc_stall}, {1'b0, eg});
        @(posedge clk);
        #1;
        check(req, {3'b0, snp_retry}, {3'b0, er});
    endtask

    localparam logic [8:0] LOC = 9'd1 << B_LOC;
    localparam logic [8:0] SNP = 9'd1 << B_SNP;

    task automatic t_reset();
        @(negedge clk);
        snp_req = 1'b1; burst_busy = 1'b1;
        @(posedge clk); #1;
        check("R10 retry in reset", {3'b0, snp_retry}, 4'b0);
        @(negedge clk);
        snp_req = 1'b0; burst_busy = 1'b0; rst_n = 1'b1;
        @(posedge clk); #1;
        check("R10 retry after reset", {3'b0, snp_retry}, 4'b0);
        cyc(SNP, 3'b100, 1'b0, "R10 no leftover busy");
    endtask

    task automatic t_priority();
        cyc(LOC | SNP, 3'b101, 1'b0, "R1 snoop wins");
        cyc(LOC, 3'b010, 1'b0, "R1 local next clock");
        cyc(SNP, 3'b100, 1'b0, "R9 granted snoop no retry");
        cyc(9'd0, 3'b000, 1'b0, "R9 idle no retry");
    endtask

    task automatic t_flags();
        cyc(LOC | SNP | (9'd1 << B_TW), 3'b010, 1'b1, "R2 tag write");
        cyc(LOC | SNP | (9'd1 << B_BB), 3'b010, 1'b1, "R3 burst busy");
        cyc(SNP | (9'd1 << B_CO), 3'b000, 1'b1, "R6 castout match");
        cyc(SNP | (9'd1 << B_OE), 3'b000, 1'b1, "R7 op edge");
        cyc(SNP | (9'd1 << B_FU), 3'b000, 1'b1, "R8 flush update");
        cyc(9'd1 << B_BB, 3'b000, 1'b0, "R9 busy without snoop");
    endtask

    task automatic t_commit();
        drtry_mode = 1'b0;
        cyc(SNP | (9'd1 << B_FA), 3'b100, 1'b0, "R4 first ack cycle granted");
        cyc(SNP, 3'b000, 1'b1, "R4 committed span");
        cyc(LOC | SNP, 3'b010, 1'b1, "R4 committed, local served");
        cyc(SNP | (9'd1 << B_LA), 3'b000, 1'b1, "R4 last ack cycle");
        cyc(SNP, 3'b100, 1'b0, "R4 span over");
    endtask

    task automatic t_modes();
        drtry_mode = 1'b0;
        cyc(SNP | (9'd1 << B_LA), 3'b000, 1'b1, "R5 no-delay ack cycle");
        cyc(SNP, 3'b100, 1'b0, "R5 no-delay after ack");
        drtry_mode = 1'b1;
        cyc(SNP | (9'd1 << B_LA), 3'b100, 1'b0, "R5 delayed ack cycle free");
        cyc(SNP, 3'b000, 1'b1, "R5 delayed blocked cycle");
        cyc(SNP, 3'b100, 1'b0, "R5 delayed after window");
        drtry_mode = 1'b0;
    endtask

    initial begin
        t_reset();
        t_priority();
        t_flags();
        t_commit();
        t_modes();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule